// File: doc/BRIEF.md
# Serial Port Register Bank with Transmit and Receive Queues

This block is a memory-mapped asynchronous serial port. Software reaches it through a word-addressed register window of byte offsets. Writing a byte to the data offset queues it for transmission. Bytes that arrive on the receive line are framed, checked and queued until software reads them. A 16-bit divisor sets the bit rate through a 16x oversampling tick: each tick lasts `divisor` clock cycles, and each serial bit lasts sixteen ticks. A bank-select bit in line control swaps the two lowest offsets between the data and interrupt-enable registers and the two divisor bytes.

Software polls a status word to see whether the port is busy and how full each queue is. A second status byte reports framing errors. The interrupt-enable register is plain storage with no effect on the logic. Each frame has one start bit, 5 to 8 data bits sent least significant bit first, and one stop bit. Parity and modem lines are not part of the block.

Top module: `uart_regbank`

## Requirements
- R1: After reset, txd is 1, the status word (0x7C) reads 0x06, line status (0x14) reads 0x60, and line control (0x0C), FIFO control (0x08) and both divisor bytes read 0.
- R2: With line-control bit 7 set, offset 0x00 reads and writes the low divisor byte and 0x04 the high divisor byte. With bit 7 clear, a write to 0x00 queues a transmit byte, a read of 0x00 takes a receive byte, and 0x04 is an 8-bit read/write storage register that leaves the divisor unchanged.
- R3: Line-control bits [1:0] select the frame's data length as 5 + value bits (0→5, 1→6, 2→7, 3→8). Transmit bits above that length are not sent, and received bits above it read as 0.
- R4: A transmitted frame is a 0 start bit, then the data bits LSB first, then a 1 stop bit. Each bit lasts 16 ticks (16 × divisor clocks), and txd is 1 whenever the transmitter is idle.
- R5: The receiver samples each data bit at the middle of the bit. It queues the byte only when the stop bit samples as 1.
- R6: A low pulse on rxd that has ended before the middle of the start bit (8 ticks) produces no byte and no error.
- R7: A stop bit that samples as 0 queues nothing and sets line-status bit 3. Reading line status clears that bit.
- R8: When FIFO-control bit 0 is 1, each queue holds 32 bytes. When it is 0, each queue holds one byte. The bit reads back as written.
- R9: Writing 1 to FIFO-control bit 1 empties the receive queue, and writing 1 to bit 2 empties the transmit queue. Both bits read back as 0.
- R10: A write to the transmit queue when it is full is discarded. A received byte that arrives when the receive queue is full is discarded.
- R11: A read of receive data while the receive queue is empty returns the last byte read and leaves the queue empty.
- R12: Status word bits: 0 busy (a frame is being sent or received), 1 transmit queue not full, 2 transmit queue empty, 3 receive queue not empty, 4 receive queue full. Line status bits: 0 data ready, 3 framing error, 5 transmit queue empty, 6 transmit queue empty and transmitter idle.
- R13: A divisor of 0 stops the tick, so no frame starts and txd stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data at 0x00) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data; bits [7:0] are used |
| bus_rdata | output | 32 | Read data for bus_addr |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
The bench fills each queue to the boundary and goes one step past it. A queue whose full flag is off by one would accept or refuse the 32nd byte wrongly. A queue that accepted a write while full would, after the depth change, reach full one write early. It sends frames of every data length in both directions, so a receiver that does not align or mask the shifted bits returns stray high bits, and a transmitter that counts bits wrong breaks the stop-bit check. It also drives a short low glitch, a frame with a bad stop bit, reads from an empty receive queue, and a transmit backlog held with a zero divisor. A design that falls back on a stale head value, lets a zero divisor tick, or does not clear the sticky error would each produce a wrong status or data value.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} frame_st_e;

  localparam logic [7:0] OFS_DATA = 8'h00;
  localparam logic [7:0] OFS_IER  = 8'h04;
  localparam logic [7:0] OFS_FCR  = 8'h08;
  localparam logic [7:0] OFS_LCR  = 8'h0C;
  localparam logic [7:0] OFS_LSR  = 8'h14;
  localparam logic [7:0] OFS_USR  = 8'h7C;

  // number of data bits for a length select
  function automatic logic [3:0] frame_bits(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction

  // last bit index of a frame for a length select
  function automatic logic [2:0] last_bit(input logic [1:0] sel);
    return 3'd4 + {1'b0, sel};
  endfunction

  // a receive shifter fills from the top; move the frame down to bit 0
  function automatic logic [7:0] rx_align(input logic [7:0] sh, input logic [1:0] sel);
    return sh >> (2'd3 - sel);
  endfunction

endpackage

// File: rtl/uart_rb_fifo.sv
module uart_rb_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             one_deep,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = one_deep ? !empty : (count == CNT_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else if (clr) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/uart_rb_baud.sv
module uart_rb_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = (divisor != '0) && (cnt >= divisor - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (divisor == '0)   cnt <= '0;
    else if (tick)            cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/uart_rb_tx.sv
module uart_rb_tx
  import uart_rb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] len_sel,
  input  logic       avail,
  input  logic [7:0] din,
  output logic       pop,
  output logic       txd,
  output logic       busy
);

  frame_st_e  st;
  logic [3:0] tcnt;
  logic [2:0] bitn;
  logic [7:0] sh;
  logic       bit_end;

  assign busy    = (st != ST_IDLE);
  assign pop     = (st == ST_IDLE) && tick && avail;
  assign bit_end = tick && (tcnt == 4'd15);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      tcnt <= '0;
      bitn <= '0;
      sh   <= '0;
      txd  <= 1'b1;
    end else begin
      if (tick && st != ST_IDLE) tcnt <= tcnt + 1'b1;
      unique case (st)
        ST_IDLE: begin
          txd <= 1'b1;
          if (pop) begin
            sh   <= din;
            tcnt <= '0;
            txd  <= 1'b0;
            st   <= ST_START;
          end
        end
        ST_START: if (bit_end) begin
          bitn <= '0;
          txd  <= sh[0];
          st   <= ST_DATA;
        end
        ST_DATA: if (bit_end) begin
          if (bitn == last_bit(len_sel)) begin
            txd <= 1'b1;
            st  <= ST_STOP;
          end else begin
            bitn <= bitn + 1'b1;
            sh   <= sh >> 1;
            txd  <= sh[1];
          end
        end
        ST_STOP: if (bit_end) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_rb_rx.sv
module uart_rb_rx
  import uart_rb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] len_sel,
  input  logic       rxd,
  output logic       push,
  output logic [7:0] data,
  output logic       frame_err,
  output logic       busy
);

  frame_st_e  st;
  logic [1:0] sync;
  logic       line, line_d;
  logic [3:0] tcnt;
  logic [2:0] bitn;
  logic [7:0] sh;
  logic       fall, mid_start, bit_mid;

  assign line      = sync[1];
  assign fall      = line_d && !line;
  assign busy      = (st != ST_IDLE);
  assign mid_start = tick && (tcnt == 4'd7);
  assign bit_mid   = tick && (tcnt == 4'd15);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync   <= 2'b11;
      line_d <= 1'b1;
    end else begin
      sync   <= {sync[0], rxd};
      line_d <= line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      tcnt      <= '0;
      bitn      <= '0;
      sh        <= '0;
      push      <= 1'b0;
      frame_err <= 1'b0;
      data      <= '0;
    end else begin
      push      <= 1'b0;
      frame_err <= 1'b0;
      if (tick && st != ST_IDLE) tcnt <= tcnt + 1'b1;
      unique case (st)
        ST_IDLE: if (fall) begin
          tcnt <= '0;
          sh   <= '0;
          st   <= ST_START;
        end
        ST_START: if (mid_start) begin
          tcnt <= '0;
          bitn <= '0;
          st   <= line ? ST_IDLE : ST_DATA;
        end
        ST_DATA: if (bit_mid) begin
          sh <= {line, sh[7:1]};
          if (bitn == last_bit(len_sel)) st <= ST_STOP;
          else bitn <= bitn + 1'b1;
        end
        ST_STOP: if (bit_mid) begin
          if (line) begin
            push <= 1'b1;
            data <= rx_align(sh, len_sel);
          end else begin
            frame_err <= 1'b1;
          end
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 32,
  parameter int DIV_W      = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              txd,
  input  logic              rxd
);

  // register state
  logic [7:0]       div_lo, div_hi, ier_q, last_rx;
  logic [1:0]       len_sel;
  logic             bank_div, fifo_en, ferr_q;
  logic [DIV_W-1:0] divisor;

  // internal events, named for the checker
  logic             tick;
  logic             tx_push, tx_pop, tx_clr, tx_empty, tx_full, tx_busy;
  logic             rx_push, rx_pop, rx_clr, rx_empty, rx_full, rx_busy, rx_ferr;
  logic [CNT_W-1:0] tx_count, rx_count;
  logic [7:0]       tx_head, rx_head, rx_byte;
  logic             wr_unused;

  // register selects
  logic sel_data, sel_ier, sel_fcr, sel_lcr, sel_lsr, sel_usr;
  assign sel_data = (bus_addr == ADDR_W'(OFS_DATA));
  assign sel_ier  = (bus_addr == ADDR_W'(OFS_IER));
  assign sel_fcr  = (bus_addr == ADDR_W'(OFS_FCR));
  assign sel_lcr  = (bus_addr == ADDR_W'(OFS_LCR));
  assign sel_lsr  = (bus_addr == ADDR_W'(OFS_LSR));
  assign sel_usr  = (bus_addr == ADDR_W'(OFS_USR));

  assign wr_unused = ^bus_wdata[DATA_W-1:8];
  assign divisor   = DIV_W'({div_hi, div_lo});

  assign tx_push = bus_wr && sel_data && !bank_div;
  assign rx_pop  = bus_rd && sel_data && !bank_div;
  assign tx_clr  = bus_wr && sel_fcr && bus_wdata[2];
  assign rx_clr  = bus_wr && sel_fcr && bus_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo   <= '0;
      div_hi   <= '0;
      ier_q    <= '0;
      len_sel  <= '0;
      bank_div <= 1'b0;
      fifo_en  <= 1'b0;
    end else if (bus_wr) begin
      if (sel_data && bank_div)  div_lo <= bus_wdata[7:0];
      if (sel_ier && bank_div)   div_hi <= bus_wdata[7:0];
      if (sel_ier && !bank_div)  ier_q  <= bus_wdata[7:0];
      if (sel_fcr)               fifo_en <= bus_wdata[0];
      if (sel_lcr) begin
        len_sel  <= bus_wdata[1:0];
        bank_div <= bus_wdata[7];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ferr_q  <= 1'b0;
      last_rx <= '0;
    end else begin
      if (rx_ferr)                    ferr_q <= 1'b1;
      else if (bus_rd && sel_lsr)     ferr_q <= 1'b0;
      if (rx_pop && !rx_empty)        last_rx <= rx_head;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_data)     bus_rdata[7:0] = bank_div ? div_lo : (rx_empty ? last_rx : rx_head);
    else if (sel_ier) bus_rdata[7:0] = bank_div ? div_hi : ier_q;
    else if (sel_fcr) bus_rdata[0]   = fifo_en;
    else if (sel_lcr) bus_rdata[7:0] = {bank_div, 5'b0, len_sel};
    else if (sel_lsr) bus_rdata[7:0] = {1'b0, tx_empty && !tx_busy, tx_empty, 1'b0,
                                        ferr_q, 2'b0, !rx_empty};
    else if (sel_usr) bus_rdata[4:0] = {rx_full, !rx_empty, tx_empty, !tx_full,
                                        tx_busy || rx_busy};
  end

  uart_rb_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
  );

  uart_rb_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .one_deep(!fifo_en),
    .push(tx_push), .din(bus_wdata[7:0]), .pop(tx_pop), .dout(tx_head),
    .count(tx_count), .empty(tx_empty), .full(tx_full)
  );

  uart_rb_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .one_deep(!fifo_en),
    .push(rx_push), .din(rx_byte), .pop(rx_pop), .dout(rx_head),
    .count(rx_count), .empty(rx_empty), .full(rx_full)
  );

  uart_rb_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .len_sel(len_sel),
    .avail(!tx_empty), .din(tx_head), .pop(tx_pop), .txd(txd), .busy(tx_busy)
  );

  uart_rb_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .len_sel(len_sel), .rxd(rxd),
    .push(rx_push), .data(rx_byte), .frame_err(rx_ferr), .busy(rx_busy)
  );

endmodule

// File: rtl/uart_rb_checker.sv
module uart_rb_checker #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6,
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             txd,
  input logic             tx_busy,
  input logic             tx_clr,
  input logic             rx_clr,
  input logic             tx_full,
  input logic             rx_full,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] rx_count,
  input logic [DIV_W-1:0] divisor
);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd); // R4

  AST_NO_TICK_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> !tick); // R13

  AST_TX_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CNT_W'(DEPTH)); // R8

  AST_RX_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(DEPTH)); // R8

  AST_TX_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |=> (tx_count == '0)); // R9

  AST_RX_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (rx_count == '0)); // R9

  AST_TX_FULL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !tx_clr) |=> (tx_count <= $past(tx_count))); // R10

  AST_RX_FULL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_clr) |=> (rx_count <= $past(rx_count))); // R10

endmodule

bind uart_regbank uart_rb_checker #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .txd(txd), .tx_busy(tx_busy),
  .tx_clr(tx_clr), .rx_clr(rx_clr), .tx_full(tx_full), .rx_full(rx_full),
  .tx_count(tx_count), .rx_count(rx_count), .divisor(divisor)
);

// File: tb/uart_regbank_bench.sv
module uart_regbank_bench;

  localparam int DIV = 2;
  localparam int BIT = 16 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        txd;
  logic        rxd = 1'b1;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // scoreboard queues: expected byte and its data length
  int exp_b[$];
  int exp_n[$];

  always #4 clk = ~clk;

  uart_regbank u_uart_regbank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .rxd(rxd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] e);
    logic [31:0] v;
    bus_read(a, v);
    chk(req, v, e);
  endtask

  task automatic set_div(input logic [15:0] d, input logic [1:0] len);
    bus_write(8'h0C, {24'h0, 1'b1, 5'b0, len});
    bus_write(8'h00, {24'h0, d[7:0]});
    bus_write(8'h04, {24'h0, d[15:8]});
    bus_write(8'h0C, {30'h0, len});
  endtask

  // driver: queue a transmit byte and record what the line must carry
  task automatic tx_send(input logic [7:0] b, input int n);
    bus_write(8'h00, {24'h0, b});
    exp_b.push_back(int'(b) & ((1 << n) - 1));
    exp_n.push_back(n);
  endtask

  task automatic rx_frame(input logic [7:0] b, input int n, input logic stop);
    @(negedge clk);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = stop;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic tx_drain();
    while (exp_b.size() != 0) @(negedge clk);
    repeat (2 * BIT) @(negedge clk);
  endtask

  // monitor: decode txd and compare against the scoreboard
  initial begin
    forever begin
      int n;
      logic [7:0] got;
      @(negedge txd);
      n = (exp_n.size() != 0) ? exp_n[0] : 8;
      repeat (BIT / 2) @(posedge clk);
      #2 chk("R4 start bit", {31'h0, txd}, 32'h0);
      got = '0;
      for (int i = 0; i < n; i++) begin
        repeat (BIT) @(posedge clk);
        #2 got[i] = txd;
      end
      repeat (BIT) @(posedge clk);
      #2 chk("R4 stop bit", {31'h0, txd}, 32'h1);
      if (exp_b.size() == 0) begin
        chk("R13 unexpected frame", {24'h0, got}, 32'hFFFF_FFFF);
      end else begin
        chk("R4 R3 tx byte", {24'h0, got}, exp_b[0]);
        void'(exp_b.pop_front());
        void'(exp_n.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 txd idle", {31'h0, txd}, 32'h1);
    expect_reg("R1 R12 status", 8'h7C, 32'h06);
    expect_reg("R1 R12 line status", 8'h14, 32'h60);
    expect_reg("R1 line control", 8'h0C, 32'h0);
    expect_reg("R1 fifo control", 8'h08, 32'h0);
    bus_write(8'h0C, 32'h80);
    expect_reg("R1 divisor low", 8'h00, 32'h0);
    expect_reg("R1 divisor high", 8'h04, 32'h0);
    bus_write(8'h0C, 32'h03);

    // R8 R10 R13: one-deep queue, divisor still 0
    bus_write(8'h00, 32'hA5);
    expect_reg("R8 one deep full", 8'h7C, 32'h00);
    bus_write(8'h00, 32'h5A);            // dropped, R10
    bus_write(8'h08, 32'h01);            // deep mode, keep contents
    expect_reg("R10 R8 one entry kept", 8'h7C, 32'h02);
    for (int i = 0; i < 30; i++) bus_write(8'h00, i);
    expect_reg("R8 31 entries not full", 8'h7C, 32'h02);
    bus_write(8'h00, 32'h77);
    expect_reg("R8 32 entries full", 8'h7C, 32'h00);
    bus_write(8'h00, 32'h78);            // dropped, R10
    expect_reg("R10 full write dropped", 8'h7C, 32'h00);
    repeat (200) @(negedge clk);
    chk("R13 zero divisor no frame", {31'h0, txd}, 32'h1);
    bus_write(8'h08, 32'h05);
    expect_reg("R9 tx clear", 8'h7C, 32'h06);
    expect_reg("R9 R8 fcr readback", 8'h08, 32'h01);

    // R2 banking
    set_div(16'(DIV), 2'd3);
    bus_write(8'h04, 32'h0F);
    expect_reg("R2 ier storage", 8'h04, 32'h0F);
    bus_write(8'h0C, 32'h83);
    expect_reg("R2 divisor low bank", 8'h00, DIV);
    expect_reg("R2 divisor high bank", 8'h04, 32'h00);
    expect_reg("R2 lcr readback", 8'h0C, 32'h83);
    bus_write(8'h0C, 32'h03);
    repeat (2 * BIT) @(negedge clk);
    chk("R2 no frame from divisor write", {31'h0, txd}, 32'h1);

    // R4 R3 transmit, all lengths
    tx_send(8'h55, 8);
    repeat (3 * BIT) @(negedge clk);
    bus_read(8'h7C, v);
    chk("R12 busy while sending", v & 32'h1, 32'h1);
    tx_send(8'hA3, 8);
    tx_send(8'h0F, 8);
    tx_drain();
    expect_reg("R12 line status idle", 8'h14, 32'h60);
    for (int len = 0; len < 3; len++) begin
      bus_write(8'h0C, len);
      tx_send(8'hBA, 5 + len);
      tx_send(8'hC5, 5 + len);
      tx_drain();
    end

    // R5 R3 receive
    bus_write(8'h0C, 32'h03);
    rx_frame(8'h5A, 8, 1'b1);
    expect_reg("R12 rx not empty", 8'h7C, 32'h0E);
    expect_reg("R12 lsr data ready", 8'h14, 32'h61);
    expect_reg("R5 rx byte", 8'h00, 32'h5A);
    bus_write(8'h0C, 32'h01);
    rx_frame(8'hFF, 6, 1'b1);
    expect_reg("R3 R5 six-bit rx", 8'h00, 32'h3F);
    bus_write(8'h0C, 32'h00);
    rx_frame(8'h15, 5, 1'b1);
    expect_reg("R3 R5 five-bit rx", 8'h00, 32'h15);
    bus_write(8'h0C, 32'h03);

    // R6 glitch
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    expect_reg("R6 glitch no byte", 8'h7C, 32'h06);
    expect_reg("R6 glitch no error", 8'h14, 32'h60);

    // R7 framing error
    rx_frame(8'h3C, 8, 1'b0);
    expect_reg("R7 no byte on bad stop", 8'h7C, 32'h06);
    expect_reg("R7 error flagged", 8'h14, 32'h68);
    expect_reg("R7 error cleared by read", 8'h14, 32'h60);

    // R10 receive overflow, R11 empty read
    for (int i = 0; i < 33; i++) rx_frame(8'((i * 7) + 1), 8, 1'b1);
    expect_reg("R12 R8 rx full", 8'h7C, 32'h1E);
    for (int i = 0; i < 32; i++) expect_reg("R10 rx order", 8'h00, 32'((i * 7) + 1) & 32'hFF);
    expect_reg("R10 extra byte dropped", 8'h7C, 32'h06);
    expect_reg("R11 empty read last value", 8'h00, 32'((31 * 7) + 1) & 32'hFF);
    expect_reg("R11 empty read again", 8'h00, 32'((31 * 7) + 1) & 32'hFF);
    expect_reg("R11 still empty", 8'h7C, 32'h06);

    // R9 receive clear
    rx_frame(8'h11, 8, 1'b1);
    rx_frame(8'h22, 8, 1'b1);
    expect_reg("R9 rx holds two", 8'h7C, 32'h0E);
    bus_write(8'h08, 32'h03);
    expect_reg("R9 rx cleared", 8'h7C, 32'h06);
    expect_reg("R9 self clear readback", 8'h08, 32'h01);

    tx_drain();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule